// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block raises a processor interrupt after software has programmed a number of visible video lines. A register write port carries an address and a data byte. A per-line strobe carries the number of the line that has just ended, and a level input tells whether rendering is switched on. Inside, the block holds a signed line counter, an 8-bit reload latch and an arm flag. It drives one active-high interrupt level.

Software can load the counter directly or copy the latch into it, and then arms the block. Each visible line with rendering on counts the counter down by one. When a visible line finds the counter at zero or below while the block is armed, the interrupt goes high. The counter then stays where it is and does not reload. Every later visible line re-raises the interrupt until software writes the acknowledge register, which also disarms the block and reloads the counter from the latch.

Register writes and line strobes are single-cycle qualifiers with no back-pressure. The block accepts one of each on every clock, so neither interface has a ready signal. If a decoded write and a visible line arrive in the same cycle, the write takes effect and that line is not counted.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset the interrupt output is low and the counter, latch and arm flag are all zero. As a result, arming the block and then sending one visible line raises the interrupt straight away.
- R2: A write decoding to 0xC000 loads the counter with the data byte, taken as an unsigned value. It leaves the arm flag and the latch unchanged.
- R3: A write decoding to 0xC001 stores the data byte in the latch and touches nothing else.
- R4: A write decoding to 0xE000 copies the latch into the counter, clears the arm flag and drives the interrupt low.
- R5: A write decoding to 0xE001 sets the arm flag.
- R6: A write is decoded by ANDing its address with 0xE001 and comparing the result with the four register addresses. Address bits outside the mask do not matter, and a write that matches none of the four addresses has no effect.
- R7: A line strobe is acted on only when the line number is between 0 and 239 inclusive. A strobe for any other line changes no state.
- R8: On an acted-on line where the counter is zero or negative and the block is armed, the interrupt goes high and the counter keeps its value.
- R9: On any other acted-on line, the counter decreases by one if rendering is on and holds its value if rendering is off.
- R10: Once high, the interrupt stays high until a write decoding to 0xE000 or a reset.
- R11: The counter is signed and 10 bits wide. While the block is disarmed it keeps counting down below zero, stops at -512, and still counts as zero or below.
- R12: The interrupt output changes on the first clock edge after the line strobe or write that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| line_stb | input | 1 | One-cycle pulse at the end of each video line |
| line_num | input | 9 | Number of the line that ended |
| render_on | input | 1 | Rendering is switched on |
| irq | output | 1 | Interrupt request, active high, held until acknowledged |

## Verification
Directed sequences load small counts and count the lines until the interrupt fires. They contrast lines with rendering on and off, and visible line numbers with off-screen ones, which separates a missing decrement from a wrong decrement or an off-by-one in the line range. Further patterns alias register addresses through the bits outside the mask, repeat the interrupt after the counter has reached zero, and drive the counter far past zero while disarmed, which shows the floor at -512 rather than a wrap to a positive value. Random mixes of writes and lines with small data values are then compared, line by line, with a reference model in the bench.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_LATCH = 3'd2,
    OP_ACK   = 3'd3,
    OP_ARM   = 3'd4
  } reg_op_e;
endpackage

// File: rtl/scanline_irq_decode.sv
module scanline_irq_decode
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SEL_MASK   = 16'hE001,
  parameter logic [ADDR_W-1:0] LOAD_ADDR  = 16'hC000,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'hC001,
  parameter logic [ADDR_W-1:0] ACK_ADDR   = 16'hE000,
  parameter logic [ADDR_W-1:0] ARM_ADDR   = 16'hE001
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output reg_op_e           op
);
  logic [ADDR_W-1:0] masked;

  assign masked = wr_addr & SEL_MASK;

  always_comb begin
    op = OP_NONE;
    if (wr_en) begin
      if (masked == LOAD_ADDR)       op = OP_LOAD;
      else if (masked == LATCH_ADDR) op = OP_LATCH;
      else if (masked == ACK_ADDR)   op = OP_ACK;
      else if (masked == ARM_ADDR)   op = OP_ARM;
    end
  end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scanline_irq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239,
  localparam int CNT_W    = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_op_e           op,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_stb,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  output logic              fire
);
  localparam logic [CNT_W-1:0] CNT_FLOOR = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [LINE_W-1:0] LAST_L   = LINE_W'(LAST_LINE);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] latch;
  logic              armed;
  logic              line_vis;
  logic              nonpos;
  logic              no_op;

  assign line_vis = line_stb && (line_num <= LAST_L);
  assign nonpos   = cnt[CNT_W-1] || (cnt == '0);
  assign no_op    = (op == OP_NONE);
  assign fire     = no_op && line_vis && armed && nonpos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      latch <= '0;
      armed <= 1'b0;
    end else begin
      unique case (op)
        OP_LOAD:  cnt <= {2'b00, wr_data};
        OP_LATCH: latch <= wr_data;
        OP_ACK: begin
          cnt   <= {2'b00, latch};
          armed <= 1'b0;
        end
        OP_ARM:   armed <= 1'b1;
        default: begin
          if (line_vis && !(armed && nonpos) && render_on && (cnt != CNT_FLOOR))
            cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  // R7
  off_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && line_num > LAST_L && no_op) |=> ($stable(cnt) && $stable(armed) && $stable(latch)));

  // R8
  hold_at_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_vis && armed && nonpos && no_op) |=> $stable(cnt));

  // R9
  no_render_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_vis && !render_on && no_op) |=> $stable(cnt));

  // R3
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LATCH) |=> (latch == $past(wr_data) && $stable(cnt) && $stable(armed)));

  // R5
  arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ARM) |=> armed);

  // R11
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_FLOOR && no_op) |=> (cnt == CNT_FLOOR));
endmodule

// File: rtl/scanline_irq_flag.sv
module scanline_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ack,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)    irq <= 1'b0;
    else if (ack)  irq <= 1'b0;
    else if (fire) irq <= 1'b1;
  end

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fire));
endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_stb,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  output logic              irq
);
  reg_op_e op;
  logic    fire;

  scanline_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .op      (op)
  );

  scanline_irq_counter #(
    .DATA_W    (DATA_W),
    .LINE_W    (LINE_W),
    .LAST_LINE (LAST_LINE)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .wr_data   (wr_data),
    .line_stb  (line_stb),
    .line_num  (line_num),
    .render_on (render_on),
    .fire      (fire)
  );

  scanline_irq_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .ack   (op == OP_ACK),
    .irq   (irq)
  );
endmodule

// File: tb/sim_scanline_irq_unit.sv
module sim_scanline_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        line_stb = 1'b0;
  logic [8:0]  line_num = '0;
  logic        render_on = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int m_cnt, m_latch;
  bit m_en, m_irq;
  bit done = 0;

  always #10 clk = ~clk;

  scanline_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_stb(line_stb), .line_num(line_num),
    .render_on(render_on), .irq(irq)
  );

  function automatic int decode(input logic [15:0] a);
    logic [15:0] m;
    m = a & 16'hE001;
    if (m == 16'hC000) return 1;
    if (m == 16'hC001) return 2;
    if (m == 16'hE000) return 3;
    if (m == 16'hE001) return 4;
    return 0;
  endfunction

  task automatic check(input string req, input bit exp);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, irq, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_latch = 0; m_en = 0; m_irq = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (decode(a))
      1: m_cnt = d;
      2: m_latch = d;
      3: begin m_cnt = m_latch; m_en = 0; m_irq = 0; end
      4: m_en = 1;
      default: ;
    endcase
  endtask

  task automatic line(input int n, input bit r);
    @(negedge clk);
    line_stb = 1'b1; line_num = 9'(n); render_on = r;
    @(negedge clk);
    line_stb = 1'b0;
    if (n <= 239) begin
      if (m_cnt <= 0 && m_en) m_irq = 1;
      else if (r && m_cnt > -512) m_cnt--;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog irq actual=%0b expected=done", irq);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1", 1'b0);
    wr(16'hE001, 8'h00);
    check("R5", 1'b0);
    line(0, 1'b1);
    // R12 visible one edge after the line strobe
    check("R1", 1'b1);
    wr(16'hE000, 8'h00);
    check("R4", 1'b0);

    // R2 direct load of 3 then arm; fires on the fourth visible line
    wr(16'hC000, 8'd3);
    wr(16'hE001, 8'h00);
    for (int i = 0; i < 3; i++) begin
      line(10 + i, 1'b1);
      check("R9", 1'b0);
    end
    line(20, 1'b1);
    check("R12", 1'b1);
    // R10 held; R8 refires without reload
    line(21, 1'b1);
    check("R10", 1'b1);
    wr(16'hC001, 8'd2);
    check("R10", 1'b1);
    wr(16'hE000, 8'h00);
    check("R4", 1'b0);
    // R4 counter now 2 from latch, disarmed
    wr(16'hE001, 8'h00);
    line(5, 1'b0);
    line(6, 1'b0);
    // R9 render off holds count
    check("R9", 1'b0);
    line(7, 1'b1);
    line(8, 1'b1);
    check("R9", 1'b0);
    line(9, 1'b1);
    check("R8", 1'b1);

    // R7 off-screen lines ignored
    wr(16'hE000, 8'h00);
    wr(16'hC000, 8'd2);
    wr(16'hE001, 8'h00);
    for (int i = 240; i < 262; i++) line(i, 1'b1);
    line(239, 1'b1);
    check("R7", 1'b0);
    line(0, 1'b1);
    check("R7", 1'b0);
    line(1, 1'b1);
    check("R7", 1'b1);

    // R6 aliasing and unmatched addresses
    do_reset();
    wr(16'h0001, 8'h00);
    wr(16'h4001, 8'h00);
    wr(16'h6001, 8'h00);
    line(3, 1'b1);
    check("R6", 1'b0);
    wr(16'hDFFE, 8'd1);
    wr(16'hFFFF, 8'h00);
    line(4, 1'b1);
    check("R6", 1'b0);
    line(5, 1'b1);
    check("R6", 1'b1);
    wr(16'hFFFE, 8'h00);
    check("R6", 1'b0);

    // R3 latch only: latch write then arm leaves count at 0
    do_reset();
    wr(16'hC001, 8'd50);
    wr(16'hE001, 8'h00);
    line(1, 1'b1);
    check("R3", 1'b1);

    // R11 counts below zero while disarmed and stops at -512
    do_reset();
    for (int i = 0; i < 600; i++) line(i % 240, 1'b1);
    wr(16'hE001, 8'h00);
    line(2, 1'b1);
    check("R11", 1'b1);

    // random mix against the model
    do_reset();
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 3) begin
        logic [15:0] a;
        logic [7:0] d;
        a = 16'($urandom());
        case ($urandom_range(0, 4))
          0: a = (a & 16'h1FFE) | 16'hC000;
          1: a = (a & 16'h1FFE) | 16'hC001;
          2: a = (a & 16'h1FFE) | 16'hE000;
          3: a = (a & 16'h1FFE) | 16'hE001;
          default: ;
        endcase
        d = ($urandom_range(0, 7) == 0) ? 8'($urandom()) : 8'($urandom_range(0, 6));
        wr(a, d);
        check("R6", m_irq);
      end else begin
        line($urandom_range(0, 261), ($urandom_range(0, 3) != 0));
        check("R8", m_irq);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule